// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is the control and status register of a real-time clock. It sits between a simple host register bus and the timekeeping core. It keeps four status flags that hardware raises: low backup supply, alarm, century rollover and main-supply loss. It also keeps the alarm enable and calibration mode bits, and two handshake bits that move time values between the core's counters and a bank of user-visible timekeeping registers.

The host reads and writes bytes through a select/write strobe bus. The read data is combinational from the addressed register. Address 0 is the control byte, address 1 holds the calibration sign and code, and addresses 2 and up hold the user timekeeping bytes. The core sees single-cycle snapshot and load pulses, the user bank as load data, an active-low alarm output and the calibration fields.

Top module: `rtc_ctrl_status`

## Requirements
- R1: After reset, with no supply events, the control byte (address 0) and the calibration byte (address 1) read 0x00, alarm_n is 1 and both handshake pulses are 0. Control byte bits, 7 down to 0: low-battery flag, alarm flag, century flag, power-on flag, alarm enable, calibration mode, write control, read control.
- R2: With alarm enable 1 and calibration mode 0, an alarm_match cycle sets the alarm flag (bit 6) at the next edge, and alarm_n goes low in the same cycle.
- R3: An alarm_match with alarm enable 0 or calibration mode 1 leaves the alarm flag at 0. Clearing alarm enable leaves an alarm flag that is already set, and a low alarm_n, unchanged.
- R4: A read of address 0 returns the current flags and then clears the alarm flag and the century flag. A host write never changes either flag. When an alarm or century event falls in the same cycle as the read, the flag stays set.
- R5: A year_wrap cycle sets the century flag (bit 5) at the next edge.
- R6: The lowbat_evt and por_evt inputs set the low-battery flag (bit 7) and the power-on flag (bit 4). Writing 0 to either bit clears it. Writing 1 to it has no effect.
- R7: A 0-to-1 change of the read control bit (bit 0) gives one snap_pulse cycle and freezes the counter values of the edge that follows the write. Writing 1 again while the bit is 1 neither pulses nor recaptures.
- R8: While the write control bit (bit 1) is 1, the user bank ignores the counters and takes host writes to addresses 2 and up. With both control bits 0, host writes to the user bank are ignored.
- R9: A 1-to-0 change of the write control bit gives one load_pulse cycle. During that pulse, user_bank still holds the values the host wrote.
- R10: The calibration sign (address 1, bit 5) and code (bits 4..0) change only on writes made while calibration mode is 1. Writes at other times are ignored.
- R11: With both control bits 0 and no load pending, each user byte follows cnt_bank one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| alarm_match | input | 1 | Alarm comparator match event |
| year_wrap | input | 1 | Year counter rollover from 99 to 00 |
| lowbat_evt | input | 1 | Backup supply too low |
| por_evt | input | 1 | Main supply below switchover level |
| cnt_bank | input | N_TIME*8 | Timekeeping counter values, byte 0 lowest |
| user_bank | output | N_TIME*8 | User timekeeping registers, load data for the core |
| snap_pulse | output | 1 | One-cycle snapshot request |
| load_pulse | output | 1 | One-cycle transfer request into the counters |
| alarm_n | output | 1 | Active-low alarm output |
| cal_mode | output | 1 | Calibration mode bit |
| cal_sign | output | 1 | Calibration sign |
| cal_code | output | 5 | Calibration code |

## Verification
Register writes and flag events take effect at the edge that ends their cycle, so alarm_n, the flags and the calibration fields are due one edge after the stimulus. A read returns data in the same cycle, and the flags clear at that edge. Snap_pulse and load_pulse come one edge after the control bit changes, so two edges after the write. Tracking resumes two edges after the load pulse. The bench drives everything on the falling edge and samples on the next falling edge, counting those edges for each result. Alarm gating and calibration write gating are swept over every enable combination and every write value.

// File: rtl/rtc_cs_pkg.sv
package rtc_cs_pkg;
  localparam int DW = 8;
  localparam int CAL_W = 5;
  localparam int B_LB  = 7;
  localparam int B_AF  = 6;
  localparam int B_CF  = 5;
  localparam int B_POR = 4;
  localparam int B_AEN = 3;
  localparam int B_CAL = 2;
  localparam int B_W   = 1;
  localparam int B_R   = 0;

  typedef struct packed {
    logic lb;
    logic af;
    logic cf;
    logic por;
    logic aen;
    logic cal;
    logic w;
    logic r;
  } ctrl_t;
endpackage

// File: rtl/rtc_cs_ctrl_reg.sv
module rtc_cs_ctrl_reg
  import rtc_cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ctrl_rd,
  input  logic [DW-1:0] wdata,
  input  logic          alarm_match,
  input  logic          year_wrap,
  input  logic          lowbat_evt,
  input  logic          por_evt,
  output ctrl_t         ctrl_q
);
  ctrl_t ctrl_d;
  logic  ctrl_en;
  logic  alarm_set;

  assign alarm_set = alarm_match & ctrl_q.aen & ~ctrl_q.cal;
  assign ctrl_en   = ctrl_wr | ctrl_rd | alarm_match | year_wrap | lowbat_evt | por_evt;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_rd) begin
      ctrl_d.af = 1'b0;
      ctrl_d.cf = 1'b0;
    end
    if (ctrl_wr) begin
      ctrl_d.lb  = ctrl_q.lb  & wdata[B_LB];
      ctrl_d.por = ctrl_q.por & wdata[B_POR];
      ctrl_d.aen = wdata[B_AEN];
      ctrl_d.cal = wdata[B_CAL];
      ctrl_d.w   = wdata[B_W];
      ctrl_d.r   = wdata[B_R];
    end
    // events set after any clear so that none is lost
    if (alarm_set)  ctrl_d.af  = 1'b1;
    if (year_wrap)  ctrl_d.cf  = 1'b1;
    if (lowbat_evt) ctrl_d.lb  = 1'b1;
    if (por_evt)    ctrl_d.por = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/rtc_cs_cal_reg.sv
module rtc_cs_cal_reg #(
  parameter int CAL_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_wr,
  input  logic             cal_mode,
  input  logic [DW-1:0]    wdata,
  output logic             cal_sign,
  output logic [CAL_W-1:0] cal_code
);
  logic             cal_en;
  logic             sign_d;
  logic [CAL_W-1:0] code_d;

  assign cal_en = cal_wr & cal_mode;

  always_comb begin
    sign_d = wdata[CAL_W];
    code_d = wdata[CAL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_sign <= 1'b0;
      cal_code <= '0;
    end else if (cal_en) begin
      cal_sign <= sign_d;
      cal_code <= code_d;
    end
  end
endmodule

// File: rtl/rtc_cs_edge.sv
module rtc_cs_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic prev,
  output logic fire,
  output logic pulse
);
  generate
    if (RISE) begin : g_rise
      assign fire = level & ~prev;
    end else begin : g_fall
      assign fire = ~level & prev;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      prev  <= level;
      pulse <= fire;
    end
  end
endmodule

// File: rtl/rtc_cs_user_bank.sv
module rtc_cs_user_bank #(
  parameter int N_TIME = 7,
  parameter int DW     = 8,
  parameter int IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 track,
  input  logic                 capture,
  input  logic                 freeze,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wdata,
  input  logic [N_TIME*DW-1:0] cnt_bank,
  output logic [N_TIME*DW-1:0] bank_q
);
  genvar gi;
  generate
    for (gi = 0; gi < N_TIME; gi++) begin : g_byte
      logic [DW-1:0] byte_d;
      logic          byte_en;
      logic          host_hit;

      assign host_hit = freeze & wr_en & (wr_idx == IDX_W'(gi));

      always_comb begin
        byte_en = 1'b0;
        byte_d  = bank_q[gi*DW +: DW];
        if (track | capture) begin
          byte_en = 1'b1;
          byte_d  = cnt_bank[gi*DW +: DW];
        end else if (host_hit) begin
          byte_en = 1'b1;
          byte_d  = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q[gi*DW +: DW] <= '0;
        else if (byte_en) bank_q[gi*DW +: DW] <= byte_d;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_ctrl_status.sv
module rtc_ctrl_status
  import rtc_cs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_TIME = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 alarm_match,
  input  logic                 year_wrap,
  input  logic                 lowbat_evt,
  input  logic                 por_evt,
  input  logic [N_TIME*DW-1:0] cnt_bank,
  output logic [N_TIME*DW-1:0] user_bank,
  output logic                 snap_pulse,
  output logic                 load_pulse,
  output logic                 alarm_n,
  output logic                 cal_mode,
  output logic                 cal_sign,
  output logic [CAL_W-1:0]     cal_code
);
  localparam int IDX_W = (N_TIME > 1) ? $clog2(N_TIME) : 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CAL_A  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] USER_A = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(2 + N_TIME - 1);

  ctrl_t            ctrl_q;
  logic [DW-1:0]    ctrl_byte;
  logic             ctrl_hit, cal_hit, user_hit;
  logic [IDX_W-1:0] user_idx;
  logic             r_prev, r_fire;
  logic             w_prev, w_fire;
  logic             track, capture;

  assign ctrl_hit = (bus_addr == CTRL_A);
  assign cal_hit  = (bus_addr == CAL_A);
  assign user_hit = (bus_addr >= USER_A) && (bus_addr <= LAST_A);
  assign user_idx = IDX_W'(bus_addr - USER_A);

  rtc_cs_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (bus_sel & bus_we & ctrl_hit),
    .ctrl_rd     (bus_sel & ~bus_we & ctrl_hit),
    .wdata       (bus_wdata),
    .alarm_match (alarm_match),
    .year_wrap   (year_wrap),
    .lowbat_evt  (lowbat_evt),
    .por_evt     (por_evt),
    .ctrl_q      (ctrl_q)
  );

  assign ctrl_byte = ctrl_q;
  assign cal_mode  = ctrl_q.cal;
  assign alarm_n   = ~ctrl_q.af;

  rtc_cs_cal_reg #(.CAL_W(CAL_W), .DW(DW)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_wr   (bus_sel & bus_we & cal_hit),
    .cal_mode (ctrl_q.cal),
    .wdata    (bus_wdata),
    .cal_sign (cal_sign),
    .cal_code (cal_code)
  );

  rtc_cs_edge #(.RISE(1'b1)) u_snap_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ctrl_q.r),
    .prev  (r_prev),
    .fire  (r_fire),
    .pulse (snap_pulse)
  );

  rtc_cs_edge #(.RISE(1'b0)) u_load_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ctrl_q.w),
    .prev  (w_prev),
    .fire  (w_fire),
    .pulse (load_pulse)
  );

  // tracking pauses through the transfer so the core loads host values
  assign track   = ~ctrl_q.r & ~ctrl_q.w & ~w_prev & ~load_pulse & ~w_fire;
  assign capture = r_fire & ~ctrl_q.w;

  rtc_cs_user_bank #(.N_TIME(N_TIME), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .track    (track),
    .capture  (capture),
    .freeze   (ctrl_q.w),
    .wr_en    (bus_sel & bus_we & user_hit),
    .wr_idx   (user_idx),
    .wdata    (bus_wdata),
    .cnt_bank (cnt_bank),
    .bank_q   (user_bank)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) bus_rdata = ctrl_byte;
    if (cal_hit)  bus_rdata = {{(DW-CAL_W-1){1'b0}}, cal_sign, cal_code};
    for (int i = 0; i < N_TIME; i++) begin
      if (user_hit && (user_idx == IDX_W'(i))) bus_rdata = user_bank[i*DW +: DW];
    end
  end
endmodule

// File: rtl/rtc_ctrl_status_chk.sv
module rtc_ctrl_status_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              alarm_match,
  input logic              year_wrap,
  input logic              lowbat_evt,
  input logic [7:0]        ctrl_byte,
  input logic              cal_sign,
  input logic [4:0]        cal_code,
  input logic              snap_pulse,
  input logic              load_pulse
);
  logic past_ok;
  logic ctrl_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign ctrl_rd = bus_sel & ~bus_we & (bus_addr == '0);

  p_af_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[6] && !(alarm_match && ctrl_byte[3] && !ctrl_byte[2])) |=> !ctrl_byte[6]);

  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !alarm_match) |=> !ctrl_byte[6]);

  p_cf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[5] && !year_wrap) |=> !ctrl_byte[5]);

  p_lb_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[7] && !lowbat_evt) |=> !ctrl_byte[7]);

  p_snap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_pulse |=> !snap_pulse);

  p_load_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && load_pulse) |-> !$past(ctrl_byte[1]));

  p_cal_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_byte[2] |=> ($stable(cal_code) && $stable(cal_sign)));
endmodule

bind rtc_ctrl_status rtc_ctrl_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .alarm_match (alarm_match),
  .year_wrap   (year_wrap),
  .lowbat_evt  (lowbat_evt),
  .ctrl_byte   (ctrl_byte),
  .cal_sign    (cal_sign),
  .cal_code    (cal_code),
  .snap_pulse  (snap_pulse),
  .load_pulse  (load_pulse)
);

// File: tb/rtc_ctrl_status_tb.sv
module rtc_ctrl_status_tb;
  localparam int ADDR_W = 4;
  localparam int N_TIME = 7;
  localparam int BW = N_TIME * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          alarm_match = 1'b0, year_wrap = 1'b0, lowbat_evt = 1'b0, por_evt = 1'b0;
  logic [BW-1:0] cnt_bank = '0;
  logic [BW-1:0] user_bank;
  logic          snap_pulse, load_pulse, alarm_n, cal_mode, cal_sign;
  logic [4:0]    cal_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  rtc_ctrl_status #(.ADDR_W(ADDR_W), .N_TIME(N_TIME)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_match(alarm_match), .year_wrap(year_wrap), .lowbat_evt(lowbat_evt),
    .por_evt(por_evt), .cnt_bank(cnt_bank), .user_bank(user_bank),
    .snap_pulse(snap_pulse), .load_pulse(load_pulse), .alarm_n(alarm_n),
    .cal_mode(cal_mode), .cal_sign(cal_sign), .cal_code(cal_code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] va, vb;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdreg(4'd0, rd); chk("R1 ctrl reset", rd, 8'h00);
    rdreg(4'd1, rd); chk("R1 cal reset", rd, 8'h00);
    chk("R1 alarm_n reset", alarm_n, 1'b1);
    chk("R1 pulses reset", {snap_pulse, load_pulse}, 2'b00);

    // R11 tracking
    va = 56'h11_22_33_44_55_66_77;
    cnt_bank = va;
    idle(1);
    chk("R11 tracking", user_bank, va);

    // R6 supply flags
    lowbat_evt = 1'b1; idle(1); lowbat_evt = 1'b0;
    rdreg(4'd0, rd); chk("R6 lb set", rd[7], 1'b1);
    wr(4'd0, 8'h80);
    rdreg(4'd0, rd); chk("R6 lb write1 no effect", rd[7], 1'b1);
    wr(4'd0, 8'h00);
    rdreg(4'd0, rd); chk("R6 lb write0 clears", rd[7], 1'b0);
    por_evt = 1'b1; idle(1); por_evt = 1'b0;
    rdreg(4'd0, rd); chk("R6 por set", rd[4], 1'b1);
    wr(4'd0, 8'h10);
    rdreg(4'd0, rd); chk("R6 por write1 no effect", rd[4], 1'b1);
    wr(4'd0, 8'h00);
    rdreg(4'd0, rd); chk("R6 por write0 clears", rd[4], 1'b0);

    // R2 / R3 gating sweep
    for (int m = 0; m < 4; m++) begin
      logic aen, cm;
      aen = m[1]; cm = m[0];
      wr(4'd0, {4'b0, aen, cm, 2'b00});
      alarm_match = 1'b1; idle(1); alarm_match = 1'b0;
      chk((aen && !cm) ? "R2 alarm_n low" : "R3 alarm_n gated", alarm_n, !(aen && !cm));
      rdreg(4'd0, rd);
      chk((aen && !cm) ? "R2 af set" : "R3 af gated", rd[6], aen && !cm);
      chk("R4 af cleared by read", alarm_n, 1'b1);
    end

    // R3 clearing enable keeps flag; R4 write does not touch af
    wr(4'd0, 8'h08);
    alarm_match = 1'b1; idle(1); alarm_match = 1'b0;
    wr(4'd0, 8'h00);
    chk("R3 alarm_n held after aen clear", alarm_n, 1'b0);
    rdreg(4'd0, rd); chk("R3 af held after aen clear", rd[6], 1'b1);
    wr(4'd0, 8'h40);
    rdreg(4'd0, rd); chk("R4 write cannot set af", rd[6], 1'b0);

    // R4 same-cycle event wins
    wr(4'd0, 8'h08);
    alarm_match = 1'b1; idle(1);
    year_wrap = 1'b1;
    rdreg(4'd0, rd);
    alarm_match = 1'b0; year_wrap = 1'b0;
    chk("R4 read shows af", rd[6], 1'b1);
    rdreg(4'd0, rd); chk("R4 same-cycle af kept cf kept", rd[6:5], 2'b11);
    rdreg(4'd0, rd); chk("R4 cleared after second read", rd[6:5], 2'b00);

    // R5 century flag
    wr(4'd0, 8'h00);
    year_wrap = 1'b1; idle(1); year_wrap = 1'b0;
    rdreg(4'd0, rd); chk("R5 cf set", rd[5], 1'b1);
    rdreg(4'd0, rd); chk("R5 cf cleared by read", rd[5], 1'b0);

    // R10 calibration write gating sweep
    for (int v = 0; v < 64; v++) begin
      wr(4'd1, 8'(v));
      rdreg(4'd1, rd);
      chk("R10 cal write ignored", rd, 8'h00);
    end
    wr(4'd0, 8'h04);
    chk("R10 cal_mode out", cal_mode, 1'b1);
    for (int v = 0; v < 64; v++) begin
      wr(4'd1, 8'(v) | 8'hC0);
      rdreg(4'd1, rd);
      chk("R10 cal write accepted", rd, 8'(v));
    end
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h15);
    chk("R10 cal ports held", {cal_sign, cal_code}, 6'h3F);

    // R7 snapshot
    cnt_bank = 56'h01_02_03_04_05_06_07;
    wr(4'd0, 8'h01);
    chk("R7 no pulse yet", snap_pulse, 1'b0);
    va = 56'hA1_A2_A3_A4_A5_A6_A7;
    cnt_bank = va;
    idle(1);
    chk("R7 snap pulse", snap_pulse, 1'b1);
    chk("R7 captured", user_bank, va);
    cnt_bank = 56'hB1_B2_B3_B4_B5_B6_B7;
    idle(1);
    chk("R7 pulse single", snap_pulse, 1'b0);
    chk("R7 image static", user_bank, va);
    wr(4'd0, 8'h01); idle(1);
    chk("R7 hold no pulse", snap_pulse, 1'b0);
    chk("R7 hold no recapture", user_bank, va);

    // R8 ignored writes with both bits 0
    wr(4'd0, 8'h00);
    idle(1);
    vb = 56'hC1_C2_C3_C4_C5_C6_C7;
    cnt_bank = vb;
    wr(4'd2, 8'h99);
    chk("R8 write ignored when not frozen", user_bank, vb);

    // R8 freeze and host writes
    wr(4'd0, 8'h02);
    wr(4'd2, 8'h5A);
    wr(4'd8, 8'hE7);
    cnt_bank = 56'hD1_D2_D3_D4_D5_D6_D7;
    idle(2);
    va = {8'hE7, vb[47:8], 8'h5A};
    chk("R8 frozen with host data", user_bank, va);
    rdreg(4'd8, rd); chk("R8 readback", rd, 8'hE7);

    // R9 transfer
    wr(4'd0, 8'h00);
    chk("R9 no pulse yet", load_pulse, 1'b0);
    idle(1);
    chk("R9 load pulse", load_pulse, 1'b1);
    chk("R9 bank holds host data", user_bank, va);
    idle(1);
    chk("R9 pulse single", load_pulse, 1'b0);
    idle(1);
    chk("R11 tracking resumes", user_bank, 56'hD1_D2_D3_D4_D5_D6_D7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule